// File: doc/BRIEF.md
# Self-Clocked Serial Result Port

This block is the digital output side of a converter that makes its own serial clock. It waits for a conversion to finish and then sends the result as a 24-bit frame on a data line, timed by a clock it generates on a second line. The level of the data line tells a listener what the converter is doing. High means a conversion is running. Low means a result is ready. The first bit of every frame repeats that status as a zero.

A `start` pulse brings the port out of its powered-down state. The port then begins its first conversion. Each conversion is modelled as a fixed number of system clock cycles. After that time the port accepts one result word through a valid/ready handshake. The producer presents `res_data` with `res_valid` and must hold both until a cycle in which `res_ready` is also high; that cycle transfers the word. `res_ready` is low at all other times, including the whole of every frame and sleep period. Each frame therefore takes exactly one word.

While a result waits, the port sleeps with both lines low. The frame starts once the active-low chip select has been low for half a serial clock period. A shorter low pulse only reads the status. Raising chip select during a frame ends the frame at once. With chip select held low, the port alternates between conversions and frames without any outside action.

Top module: `oport_sdo_tx`

## Requirements
- R1: After reset and before the first `start` pulse, `sck_oe`, `sdo_oe` and `res_ready` are all 0.
- R2: A conversion begins on the clock edge that samples `start` high, and again after every frame. During it `sck` is 1 and `sdo` is 1. `res_ready` stays 0 for the first CONV_CYC cycles of the conversion. It then stays 1 until a word is transferred (`res_valid` and `res_ready` both high in one cycle).
- R3: In the cycle after a transfer the port is asleep: `sck` is 0, `sdo` is 0 (status bit 0 = result ready) and `res_ready` is 0.
- R4: The first rising edge of `sck` comes only after `cs_n` has been low for SCK_DIV/2 consecutive cycles in sleep. A shorter low pulse drives `sdo` to 0 while `cs_n` is low and starts no frame.
- R5: A frame has exactly 24 rising edges of `sck`. Each high phase and each low phase inside it lasts SCK_DIV/2 cycles. After the 24th high phase, `sck` stays high.
- R6: Inside a frame, `sdo` changes only in the cycle where `sck` falls. It holds its value for the whole high phase.
- R7: At rising edge 1, `sdo` is 0 (the status bit). At rising edge k, for k from 2 to 24, `sdo` is `res_data[24-k]`, so the most significant bit comes first.
- R8: When a frame completes, `sdo` returns to 1 and a new conversion begins, with `res_ready` back at 0.
- R9: While `cs_n` is 1, `sdo_oe` is 0. `sck_oe` stays 1 at all times after `start`.
- R10: If `cs_n` goes high during a frame, `sck` is high in the next cycle and a new conversion begins. The unsent bits are discarded, and the next frame carries only the next word.
- R11: With `cs_n` held low, frames for consecutive words follow one another, with one conversion between each pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that ends the powered-down state |
| cs_n | input | 1 | Active-low chip select |
| res_valid | input | 1 | Result word valid |
| res_ready | output | 1 | Port can take a result word |
| res_data | input | DATA_W | Result bits that follow the status bit, most significant bit first |
| sck | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Output enable for `sck` |
| sdo | output | 1 | Serial data and status level |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
Two situations are hard to reach from the ports. The first is a chip-select status probe that must fall inside the sleep period and be one cycle too short to start a frame. The bench holds chip select high while it hands over a word. It then drops chip select for exactly half a clock period less one cycle, and checks that `sck` stays low afterwards. The second is a frame cut off mid-way. The bench counts rising edges of `sck` and raises chip select during the high phase of the fifth bit. Its scoreboard expects only those five bits, followed directly by the next full word, which proves the remaining bits were dropped.

// File: rtl/oport_pkg.sv
`timescale 1ns/1ps
package oport_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_SHIFT = 2'd3
  } oport_state_e;

  function automatic int cnt_w(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/oport_delay.sv
`timescale 1ns/1ps
module oport_delay #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int W = oport_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIM);

  AST_DELAY_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done) else $error("delay left saturation"); // R4

endmodule

// File: rtl/oport_clkgen.sv
`timescale 1ns/1ps
module oport_clkgen #(
  parameter int SCK_DIV = 8,
  parameter int FRAME_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck_hi,
  output logic fall_stb,
  output logic last_stb
);
  localparam int HALF = SCK_DIV / 2;
  localparam int PW   = (SCK_DIV < 2) ? 1 : $clog2(SCK_DIV);
  localparam int BW   = (FRAME_W < 2) ? 1 : $clog2(FRAME_W);
  localparam logic [PW-1:0] PH_HI_END = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_WRAP   = PW'(SCK_DIV - 1);
  localparam logic [PW-1:0] PH_HALF   = PW'(HALF);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;
  logic          end_hi;
  logic          is_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (phase_q == PH_WRAP) begin
      phase_q <= '0;
      bit_q   <= bit_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign end_hi   = run && (phase_q == PH_HI_END);
  assign is_last  = (bit_q == BIT_LAST);
  assign fall_stb = end_hi && !is_last;
  assign last_stb = end_hi && is_last;
  assign sck_hi   = (phase_q < PH_HALF);

  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_q <= BIT_LAST)) else $error("bit count past frame"); // R5

  AST_FALL_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && run) |=> (!run || !sck_hi)) else $error("no fall after strobe"); // R5

endmodule

// File: rtl/oport_shifter.sv
`timescale 1ns/1ps
module oport_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '1;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b1};
  end

  assign msb = sh_q[W-1];

  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(msb)) else $error("data bit moved"); // R6

endmodule

// File: rtl/oport_sdo_tx.sv
`timescale 1ns/1ps
module oport_sdo_tx #(
  parameter int DATA_W   = 23,
  parameter int SCK_DIV  = 8,
  parameter int CONV_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cs_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              sck,
  output logic              sck_oe,
  output logic              sdo,
  output logic              sdo_oe
);
  import oport_pkg::*;

  localparam int FRAME_W = DATA_W + 1;
  localparam int HALF    = SCK_DIV / 2;

  oport_state_e state_q, state_d;
  logic conv_done, sleep_done;
  logic sck_hi, fall_stb, last_stb;
  logic accept, go_shift, frame_on, data_msb;

  assign frame_on  = (state_q == ST_SHIFT);
  assign res_ready = (state_q == ST_CONV) && conv_done;
  assign accept    = res_valid && res_ready;
  assign go_shift  = (state_q == ST_SLEEP) && !cs_n && sleep_done;

  oport_delay #(.LIMIT(CONV_CYC)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_CONV),
    .done(conv_done)
  );

  oport_delay #(.LIMIT(HALF - 1)) u_sleep_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr((state_q != ST_SLEEP) || cs_n),
    .done(sleep_done)
  );

  oport_clkgen #(.SCK_DIV(SCK_DIV), .FRAME_W(FRAME_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .run(frame_on && !cs_n),
    .sck_hi(sck_hi), .fall_stb(fall_stb), .last_stb(last_stb)
  );

  oport_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept),
    .shift(frame_on && fall_stb),
    .din({1'b0, res_data}),
    .msb(data_msb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (start) state_d = ST_CONV;
      ST_CONV:  if (accept) state_d = ST_SLEEP;
      ST_SLEEP: if (go_shift) state_d = ST_SHIFT;
      ST_SHIFT: if (cs_n || last_stb) state_d = ST_CONV;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP: begin sck = 1'b0;   sdo = 1'b0;     end
      ST_SHIFT: begin sck = sck_hi; sdo = data_msb; end
      default:  begin sck = 1'b1;   sdo = 1'b1;     end
    endcase
  end

  assign sck_oe = (state_q != ST_OFF);
  assign sdo_oe = (state_q != ST_OFF) && !cs_n;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_oe) |-> (!sdo_oe && !res_ready)) else $error("outputs live while off"); // R1

  AST_READY_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_ready) |-> (sck && sdo)) else $error("ready outside conversion"); // R2

  AST_SLEEP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!sck && !sdo && !res_ready)) else $error("no sleep after transfer"); // R3

  AST_SLEEP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_on && $past(state_q) == ST_SLEEP) |-> $past(sleep_done))
    else $error("frame began early"); // R4

  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_on && last_stb && !cs_n) |=> (sck && sdo && !res_ready))
    else $error("frame end wrong"); // R8

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_on && cs_n) |=> (sck && !res_ready)) else $error("abort failed"); // R10

endmodule

// File: tb/oport_sdo_tx_test.sv
`timescale 1ns/1ps
module oport_sdo_tx_test;
  localparam int DATA_W   = 23;
  localparam int SCK_DIV  = 8;
  localparam int CONV_CYC = 32;
  localparam int HALF     = SCK_DIV / 2;
  localparam int FRAME_W  = DATA_W + 1;

  logic clk = 1'b0;
  logic rst_n, start, cs_n, res_valid, res_ready;
  logic [DATA_W-1:0] res_data;
  logic sck, sck_oe, sdo, sdo_oe;

  always #2.5 clk = ~clk;

  oport_sdo_tx #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV), .CONV_CYC(CONV_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .sck(sck), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_rise = 0;
  bit exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop at every rising edge of sck
  logic prev_sck = 1'b1;
  logic rise_sdo = 1'b0;
  int hi_run = 100;
  int lo_run = 0;
  int rise_idx = 0;

  always @(negedge clk) begin
    if (rst_n && sck_oe) begin
      if (sck && !prev_sck) begin
        if (rise_idx > 0) check(lo_run == HALF, "R5 low phase length", lo_run, HALF);
        else              check(lo_run >= HALF, "R4 sleep before first edge", lo_run, HALF);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected sck edge", n_rise, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(sdo_oe && (sdo === e), "R7 frame bit", int'(sdo), int'(e));
        end
        rise_idx++;
        n_rise++;
        hi_run = 1;
        rise_sdo = sdo;
      end else if (sck && prev_sck) begin
        hi_run++;
        if (hi_run > HALF) rise_idx = 0;
        if (rise_idx > 0 && sdo_oe)
          check(sdo === rise_sdo, "R6 sdo held while sck high", int'(sdo), int'(rise_sdo));
      end else if (!sck && prev_sck) begin
        if (rise_idx > 0) check(hi_run == HALF, "R5 high phase length", hi_run, HALF);
        lo_run = 1;
      end else begin
        lo_run++;
      end
      prev_sck = sck;
    end
  end

  // driver: queue expected bits, then hand the word over
  task automatic send_word(input logic [DATA_W-1:0] w, input int nbits);
    logic [FRAME_W-1:0] f;
    f = {1'b0, w};
    for (int i = 0; i < nbits; i++) exp_q.push_back(f[FRAME_W-1-i]);
    res_data  = w;
    res_valid = 1'b1;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    check(!sck && !res_ready, "R3 sleep after transfer", int'(sck), 0);
    if (!cs_n) check(sdo === 1'b0, "R3 status low in sleep", int'(sdo), 0);
  endtask

  task automatic wait_frame();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (HALF + 1) @(negedge clk);
    check(sck && sdo && !res_ready, "R8 conversion after frame",
          {29'd0, sck, sdo, res_ready}, 6);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int k;
    int base;
    rst_n = 1'b0; start = 1'b0; cs_n = 1'b0; res_valid = 1'b0; res_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!sck_oe && !sdo_oe && !res_ready, "R1 quiet before start",
          {29'd0, sck_oe, sdo_oe, res_ready}, 0);

    start = 1'b1;
    k = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 0) check(sck && sdo && sck_oe, "R2 levels in conversion", {30'd0, sck, sdo}, 3);
      if (res_ready) break;
      k++;
    end
    check(k == CONV_CYC, "R2 conversion length", k, CONV_CYC);
    repeat (5) @(negedge clk);
    check(res_ready === 1'b1, "R2 ready held under back-pressure", int'(res_ready), 1);

    send_word(23'h2A5C3F, FRAME_W);
    wait_frame();
    send_word(23'h7FFFFF, FRAME_W);
    wait_frame();
    check(n_rise == 2 * FRAME_W, "R11 back-to-back frames edge count", n_rise, 2 * FRAME_W);

    // status probe in sleep
    cs_n = 1'b1;
    send_word(23'h000001, FRAME_W);
    repeat (3 * HALF) @(negedge clk);
    check(!sck && sck_oe && !sdo_oe, "R9 hi-z with chip select high",
          {29'd0, sck, sck_oe, sdo_oe}, 2);
    cs_n = 1'b0;
    @(negedge clk);
    check(sdo_oe && sdo === 1'b0, "R4 probe shows status", {30'd0, sdo_oe, sdo}, 2);
    repeat (HALF - 2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    check(sck === 1'b0, "R4 short probe starts no frame", int'(sck), 0);
    cs_n = 1'b0;
    wait_frame();

    // truncated frame
    base = n_rise;
    send_word(23'h3F00FF, 5);
    while (n_rise < base + 5) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(sck && !sdo_oe && !res_ready, "R10 abort returns to conversion",
          {29'd0, sck, sdo_oe, res_ready}, 4);
    repeat (3 * HALF) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    check(sdo === 1'b1, "R10 busy level after abort", int'(sdo), 1);
    send_word(23'h155555, FRAME_W);
    wait_frame();
    check(exp_q.size() == 0, "R10 no leftover bits", exp_q.size(), 0);
    check(n_rise == base + 5 + FRAME_W, "R10 edges after abort", n_rise, base + 5 + FRAME_W);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule